// File: doc/BRIEF.md
# Byte-Wide Host Port Master

This block is the host side of an 8-bit multiplexed port into a DSP. The port reaches three word registers behind it: control, address and data. A local client gives the block a 16-bit command: a register select, a read or write flag and, for writes, a data word. The block sends each word as two byte phases, each framed by an active-low data strobe, with a byte-identification line that marks the second half. It then waits for the target's ready line before it completes. Read words come back on a parallel bus, qualified by a one-cycle done pulse.

The target's ready line is asynchronous to the block's clock, so it passes through a synchroniser first. The block also has a helper sequence that prepares the port for bulk transfers. A single start pulse writes the control register with its byte-order bit and its extended-address bit set. It then loads the address register with a start address, so that later data accesses run low byte first and the address steps forward on its own.

Top module: `hostport_master`

## Requirements
- R1: During reset and directly after it, the strobe is high, the bus output enable is low, and busy and done are low.
- R2: The register-select output carries 2'b00 for control, 2'b01 for data with address auto-increment, 2'b10 for address and 2'b11 for data without increment. The read/write output is 1 for a read and 0 for a write. Select, read/write and byte-identification lines hold the same value from the cycle before the strobe falls until it rises, and are the same for both bytes of a word.
- R3: A word access is two strobe pulses. The byte-identification line is 0 on the first and 1 on the second. The first byte carries bits 7:0 and the second carries bits 15:8, for writes and for reads.
- R4: Each strobe pulse is low for exactly STRB_LOW clock cycles. Between the two bytes of a word the strobe is high for exactly GAP_CYC cycles.
- R5: The bus output enable is high while a write byte's strobe is low. It is low during every read strobe and during the cycle before a read strobe falls.
- R6: Read data is sampled in the last low cycle of each strobe. The assembled word is on the read-data output when done pulses.
- R7: Done is a single-cycle pulse for every completed word access. Busy is high from the cycle after acceptance until the cycle in which done is high, and the helper sequence keeps busy high across both of its accesses.
- R8: After the second byte, an access completes only once the synchronised ready input is high. When ready rises after a long low period, busy drops on the third clock edge after the rise, with two synchroniser stages.
- R9: A request is not accepted while the synchronised ready input is low. A request held through that time is accepted once ready returns high.
- R10: A local request or a helper start that arrives while busy is high is ignored.
- R11: A start pulse writes 16'h0011 to the control register (byte-order bit 0 and extended-address bit 4 set) and then writes the given start address to the address register, giving two done pulses.
- R12: When a start pulse and a local request arrive in the same cycle, the helper sequence runs and the local request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local command request |
| req_sel | input | 2 | Target register select of the command |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 16 | Write word |
| init_start | input | 1 | Starts the control/address set-up sequence |
| init_addr | input | 16 | Start address loaded by the set-up sequence |
| busy | output | 1 | Access or set-up sequence in progress |
| done | output | 1 | One-cycle pulse when a word access completes |
| rdata | output | 16 | Last word read |
| hp_sel | output | 2 | Register select to the port |
| hp_rnw | output | 1 | Read (1) / write (0) to the port |
| hp_strb_n | output | 1 | Active-low data strobe |
| hp_bytehi | output | 1 | Byte identification: 0 first byte, 1 second byte |
| hp_d_o | output | 8 | Byte driven onto the port bus |
| hp_d_oe | output | 1 | Output enable for the port bus pads |
| hp_d_i | input | 8 | Byte read from the port bus |
| hp_ready | input | 1 | Target ready, low while the target is busy |

## Verification
The bench puts a behavioural target on the port. The target measures every strobe's low time and every inter-byte gap, checks the byte-identification order and the bus enable against the direction, and reassembles words low byte first. A design that swaps the bytes, shortens a strobe or drives the bus during a read therefore corrupts the target's registers or trips a width check. The target holds ready low for a long time, and the bench checks the exact cycle in which busy falls after ready rises, so that a missing synchroniser stage or a skipped wait is caught. Requests made while ready is low, while busy, or together with a start pulse must leave the target's write count unchanged; a block that lets any of them through makes an extra write.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

   typedef enum logic [1:0] {
      HP_SEL_CTRL = 2'b00,
      HP_SEL_DINC = 2'b01,
      HP_SEL_ADDR = 2'b10,
      HP_SEL_DFIX = 2'b11
   } hp_sel_e;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_SETUP,
      ENG_STRB,
      ENG_GAP,
      ENG_TAIL
   } eng_st_e;

   typedef enum logic [2:0] {
      INI_IDLE,
      INI_CTRL_REQ,
      INI_CTRL_WAIT,
      INI_ADDR_REQ,
      INI_ADDR_WAIT
   } ini_st_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hpm_sync.sv
module hpm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[g] <= 1'b0;
            else        ff[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[g] <= 1'b0;
            else        ff[g] <= ff[g-1];
         end
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/hpm_engine.sv
module hpm_engine
   import hpm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int STRB_LOW = 2,
   parameter int GAP_CYC  = 2,
   parameter int GUARD    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  hp_sel_e               cmd_sel,
   input  logic                  cmd_rd,
   input  logic [2*BYTE_W-1:0]   cmd_wdata,
   input  logic                  rdy_s,
   output logic                  accept,
   output logic                  idle,
   output logic                  done,
   output logic [2*BYTE_W-1:0]   rdata,
   output logic [1:0]            hp_sel,
   output logic                  hp_rnw,
   output logic                  hp_strb_n,
   output logic                  hp_bytehi,
   output logic [BYTE_W-1:0]     hp_d_o,
   output logic                  hp_d_oe,
   input  logic [BYTE_W-1:0]     hp_d_i
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int CMAX   = max3(STRB_LOW, GAP_CYC, GUARD);
   localparam int CNT_W  = $clog2(CMAX + 1);

   eng_st_e             st;
   logic [CNT_W-1:0]    cnt;
   hp_sel_e             sel_q;
   logic                rd_q;
   logic                hi_q;
   logic [WORD_W-1:0]   wdata_q;
   logic [BYTE_W-1:0]   lo_q;
   logic [WORD_W-1:0]   rdata_q;
   logic                done_q;

   assign accept = (st == ENG_IDLE) && cmd_valid && rdy_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENG_IDLE;
         cnt     <= '0;
         sel_q   <= HP_SEL_CTRL;
         rd_q    <= 1'b1;
         hi_q    <= 1'b0;
         wdata_q <= '0;
         lo_q    <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ENG_IDLE: begin
               if (accept) begin
                  sel_q   <= cmd_sel;
                  rd_q    <= cmd_rd;
                  wdata_q <= cmd_wdata;
                  hi_q    <= 1'b0;
                  st      <= ENG_SETUP;
               end
            end
            ENG_SETUP: begin
               cnt <= CNT_W'(STRB_LOW - 1);
               st  <= ENG_STRB;
            end
            ENG_STRB: begin
               if (cnt == '0) begin
                  if (rd_q) begin
                     if (!hi_q) lo_q    <= hp_d_i;
                     else       rdata_q <= {hp_d_i, lo_q};
                  end
                  if (!hi_q) begin
                     cnt <= CNT_W'(GAP_CYC - 2);
                     st  <= ENG_GAP;
                  end else begin
                     cnt <= CNT_W'(GUARD);
                     st  <= ENG_TAIL;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ENG_GAP: begin
               if (cnt == '0) begin
                  hi_q <= 1'b1;
                  st   <= ENG_SETUP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ENG_TAIL: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (rdy_s) begin
                  done_q <= 1'b1;
                  st     <= ENG_IDLE;
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   assign idle      = (st == ENG_IDLE);
   assign done      = done_q;
   assign rdata     = rdata_q;
   assign hp_sel    = sel_q;
   assign hp_rnw    = rd_q;
   assign hp_strb_n = (st != ENG_STRB);
   assign hp_bytehi = hi_q;
   assign hp_d_o    = hi_q ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
   assign hp_d_oe   = !rd_q && ((st == ENG_SETUP) || (st == ENG_STRB));

   // R5: no bus drive on a read strobe nor the cycle before it
   p_oe_quiet_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hp_strb_n && hp_rnw) |-> (!hp_d_oe && !$past(hp_d_oe)));

   // R2: sampled controls already settled when the strobe is low
   p_ctl_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hp_strb_n |-> ($stable(hp_sel) && $stable(hp_rnw) && $stable(hp_bytehi)));

   // R4: a strobe pulse is never a single cycle
   p_strb_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hp_strb_n) |=> !hp_strb_n);

   // R8: completion only after synchronised ready seen high
   p_wait_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> $past(rdy_s));

   // R3: byte identification changes only while the strobe is high
   p_bytehi_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hp_bytehi) |-> hp_strb_n);
endmodule

// File: rtl/hpm_init.sv
module hpm_init
   import hpm_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int BORD_BIT  = 0,
   parameter int XADDR_BIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               eng_idle,
   input  logic [WORD_W-1:0]  start_addr,
   input  logic               eng_accept,
   input  logic               eng_done,
   output logic               active,
   output logic               cmd_valid,
   output hp_sel_e            cmd_sel,
   output logic [WORD_W-1:0]  cmd_wdata
);
   localparam logic [WORD_W-1:0] CTRL_WORD =
      (WORD_W'(1) << BORD_BIT) | (WORD_W'(1) << XADDR_BIT);

   ini_st_e            st;
   logic [WORD_W-1:0]  addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= INI_IDLE;
         addr_q <= '0;
      end else begin
         case (st)
            INI_IDLE: if (start && eng_idle) begin
               addr_q <= start_addr;
               st     <= INI_CTRL_REQ;
            end
            INI_CTRL_REQ:  if (eng_accept) st <= INI_CTRL_WAIT;
            INI_CTRL_WAIT: if (eng_done)   st <= INI_ADDR_REQ;
            INI_ADDR_REQ:  if (eng_accept) st <= INI_ADDR_WAIT;
            INI_ADDR_WAIT: if (eng_done)   st <= INI_IDLE;
            default:                       st <= INI_IDLE;
         endcase
      end
   end

   assign active    = (st != INI_IDLE);
   assign cmd_valid = (st == INI_CTRL_REQ) || (st == INI_ADDR_REQ);
   assign cmd_sel   = (st == INI_ADDR_REQ) ? HP_SEL_ADDR : HP_SEL_CTRL;
   assign cmd_wdata = (st == INI_ADDR_REQ) ? addr_q : CTRL_WORD;

   // R11: the sequence never issues a command while the engine is mid-access
   p_init_cmd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !eng_idle) |-> !eng_accept);
endmodule

// File: rtl/hostport_master.sv
module hostport_master
   import hpm_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int STRB_LOW    = 2,
   parameter int GAP_CYC     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BORD_BIT    = 0,
   parameter int XADDR_BIT   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_sel,
   input  logic                 req_rd,
   input  logic [2*BYTE_W-1:0]  req_wdata,
   input  logic                 init_start,
   input  logic [2*BYTE_W-1:0]  init_addr,
   output logic                 busy,
   output logic                 done,
   output logic [2*BYTE_W-1:0]  rdata,
   output logic [1:0]           hp_sel,
   output logic                 hp_rnw,
   output logic                 hp_strb_n,
   output logic                 hp_bytehi,
   output logic [BYTE_W-1:0]    hp_d_o,
   output logic                 hp_d_oe,
   input  logic [BYTE_W-1:0]    hp_d_i,
   input  logic                 hp_ready
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int GUARD  = SYNC_STAGES + 1;

   if (STRB_LOW < 2) begin : g_bad_strb
      $error("STRB_LOW must be at least 2");
   end
   if (GAP_CYC < 2) begin : g_bad_gap
      $error("GAP_CYC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BORD_BIT >= WORD_W || XADDR_BIT >= WORD_W || BORD_BIT == XADDR_BIT) begin : g_bad_bits
      $error("control bit positions out of range or overlapping");
   end

   logic               rdy_s;
   logic               eng_accept, eng_idle, eng_done;
   logic               ini_active, ini_valid;
   hp_sel_e            ini_sel;
   logic [WORD_W-1:0]  ini_wdata;
   logic               cmd_valid, cmd_rd;
   hp_sel_e            cmd_sel;
   logic [WORD_W-1:0]  cmd_wdata;
   logic               local_go;

   hpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(hp_ready), .q(rdy_s)
   );

   hpm_init #(.WORD_W(WORD_W), .BORD_BIT(BORD_BIT), .XADDR_BIT(XADDR_BIT)) u_init (
      .clk(clk), .rst_n(rst_n), .start(init_start), .eng_idle(eng_idle),
      .start_addr(init_addr), .eng_accept(eng_accept), .eng_done(eng_done),
      .active(ini_active), .cmd_valid(ini_valid), .cmd_sel(ini_sel),
      .cmd_wdata(ini_wdata)
   );

   assign local_go  = req_valid && !ini_active && !init_start;
   assign cmd_valid = ini_active ? ini_valid : local_go;
   assign cmd_sel   = ini_active ? ini_sel   : hp_sel_e'(req_sel);
   assign cmd_rd    = ini_active ? 1'b0      : req_rd;
   assign cmd_wdata = ini_active ? ini_wdata : req_wdata;

   hpm_engine #(.BYTE_W(BYTE_W), .STRB_LOW(STRB_LOW), .GAP_CYC(GAP_CYC), .GUARD(GUARD)) u_eng (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
      .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .rdy_s(rdy_s),
      .accept(eng_accept), .idle(eng_idle), .done(eng_done), .rdata(rdata),
      .hp_sel(hp_sel), .hp_rnw(hp_rnw), .hp_strb_n(hp_strb_n),
      .hp_bytehi(hp_bytehi), .hp_d_o(hp_d_o), .hp_d_oe(hp_d_oe), .hp_d_i(hp_d_i)
   );

   assign busy = !eng_idle || ini_active;
   assign done = eng_done;

   // R7: done lasts exactly one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: busy only starts from a request or start pulse
   p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid || init_start));

   // R9: no access starts while synchronised ready is low
   p_no_start_unready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_idle && !rdy_s) |=> eng_idle);
endmodule

// File: tb/test_hostport_master.sv
`timescale 1ns/1ps
module test_hostport_master;
   localparam int STRB = 3;
   localparam int GAP  = 4;
   localparam int XB   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_sel = 2'b00;
   logic req_rd = 1'b0;
   logic [15:0] req_wdata = '0;
   logic init_start = 1'b0;
   logic [15:0] init_addr = '0;
   logic busy, done;
   logic [15:0] rdata;
   logic [1:0] hp_sel;
   logic hp_rnw, hp_strb_n, hp_bytehi, hp_d_oe;
   logic [7:0] hp_d_o;
   logic [7:0] hp_d_i = '0;
   logic hp_ready = 1'b1;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   hostport_master #(.STRB_LOW(STRB), .GAP_CYC(GAP), .SYNC_STAGES(2),
                     .BORD_BIT(0), .XADDR_BIT(XB)) i_hostport_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_rd(req_rd), .req_wdata(req_wdata), .init_start(init_start),
      .init_addr(init_addr), .busy(busy), .done(done), .rdata(rdata),
      .hp_sel(hp_sel), .hp_rnw(hp_rnw), .hp_strb_n(hp_strb_n),
      .hp_bytehi(hp_bytehi), .hp_d_o(hp_d_o), .hp_d_oe(hp_d_oe),
      .hp_d_i(hp_d_i), .hp_ready(hp_ready)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- target model ----------------
   logic [15:0] m_ctrl = '0;
   logic [15:0] m_addr = '0;
   logic [15:0] m_mem [16];
   int wr_words = 0;
   int rdy_low = 3;
   int rdy_left = 0;
   int rel_cnt = 0;
   int rel_seen = 0;
   bit force_nr = 0;
   bit chk_rel = 0;
   bit busy_prev = 0;
   bit strb_prev = 1;
   bit mid = 0;
   bit w_rd = 0;
   logic [1:0] w_sel = '0;
   logic [7:0] cap = '0, b0 = '0;
   int low_cnt = 0, high_cnt = 0;
   logic [1:0] sel_prev = '0;
   bit rnw_prev = 1, bh_prev = 0, oe_prev = 0;

   function automatic logic [15:0] m_word(input logic [1:0] s);
      if (s == 2'b00) return m_ctrl;
      if (s == 2'b10) return m_addr;
      return m_mem[m_addr[3:0]];
   endfunction

   task automatic m_complete();
      logic [15:0] w;
      if (!w_rd) begin
         w = {cap, b0};
         case (w_sel)
            2'b00: m_ctrl = w;
            2'b10: m_addr = w;
            default: begin
               m_mem[m_addr[3:0]] = w;
               wr_words++;
               if (w_sel == 2'b01 && m_ctrl[XB]) m_addr = m_addr + 16'd1;
            end
         endcase
      end else if (w_sel == 2'b01 && m_ctrl[XB]) begin
         m_addr = m_addr + 16'd1;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic [15:0] w;
         if (strb_prev && !hp_strb_n) begin
            low_cnt = 1;
            chk(hp_sel == sel_prev && hp_rnw == rnw_prev && hp_bytehi == bh_prev,
                "R2 setup", {hp_sel, hp_rnw, hp_bytehi}, {sel_prev, rnw_prev, bh_prev});
            if (!mid) begin
               chk(hp_bytehi == 1'b0, "R3 first byte id", hp_bytehi, 0);
               w_sel = hp_sel;
               w_rd  = hp_rnw;
            end else begin
               chk(hp_bytehi == 1'b1, "R3 second byte id", hp_bytehi, 1);
               chk(hp_sel == w_sel && hp_rnw == w_rd, "R2 same controls", {hp_sel, hp_rnw}, {w_sel, w_rd});
               chk(high_cnt == GAP, "R4 gap", high_cnt, GAP);
            end
            if (w_rd) begin
               chk(!hp_d_oe && !oe_prev, "R5 read no drive", {hp_d_oe, oe_prev}, 0);
               w = m_word(w_sel);
               hp_d_i = mid ? w[15:8] : w[7:0];
            end else begin
               chk(hp_d_oe, "R5 write drive", hp_d_oe, 1);
               cap = hp_d_o;
            end
         end else if (!strb_prev && !hp_strb_n) begin
            low_cnt++;
            if (!w_rd) begin
               chk(hp_d_oe, "R5 write drive", hp_d_oe, 1);
               cap = hp_d_o;
            end else begin
               chk(!hp_d_oe, "R5 read no drive", hp_d_oe, 0);
            end
         end else if (!strb_prev && hp_strb_n) begin
            chk(low_cnt == STRB, "R4 strobe width", low_cnt, STRB);
            high_cnt = 1;
            if (!mid) begin
               b0 = cap;
               mid = 1;
            end else begin
               mid = 0;
               m_complete();
               rdy_left = rdy_low;
            end
         end else begin
            high_cnt++;
         end
         strb_prev = hp_strb_n;

         if (force_nr) begin
            hp_ready = 1'b0; rel_cnt = 0;
         end else if (rdy_left > 0) begin
            hp_ready = 1'b0; rdy_left--; rel_cnt = 0;
         end else if (!hp_ready) begin
            hp_ready = 1'b1; rel_cnt = 0;
         end else begin
            rel_cnt++;
         end
         if (chk_rel && busy_prev && !busy) begin
            chk(rel_cnt == 3, "R8 busy release latency", rel_cnt, 3);
            rel_seen++;
         end
         busy_prev = busy;
      end
      sel_prev = hp_sel;
      rnw_prev = hp_rnw;
      bh_prev  = hp_bytehi;
      oe_prev  = hp_d_oe;
   end

   // ---------------- tasks ----------------
   task automatic access(input logic [1:0] sel, input bit rd, input logic [15:0] wd,
                         output logic [15:0] ro);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_rd = rd; req_wdata = wd;
      do @(negedge clk); while (!busy);
      req_valid = 1'b0;
      do @(negedge clk); while (!done);
      ro = rdata;
      chk(!busy, "R7 busy low with done", busy, 0);
      @(negedge clk);
      chk(!done, "R7 done single cycle", done, 0);
   endtask

   task automatic t_reset();
      chk(hp_strb_n && !hp_d_oe && !busy && !done, "R1 in reset",
          {hp_strb_n, hp_d_oe, busy, done}, 4'b1000);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(hp_strb_n && !hp_d_oe && !busy && !done, "R1 after reset",
          {hp_strb_n, hp_d_oe, busy, done}, 4'b1000);
   endtask

   task automatic run_init(input logic [15:0] a, output int dones);
      dones = 0;
      @(negedge clk); init_start = 1'b1; init_addr = a;
      @(negedge clk); init_start = 1'b0;
      chk(busy, "R7 busy during set-up", busy, 1);
      while (busy) begin
         if (done) dones++;
         @(negedge clk);
      end
   endtask

   task automatic t_init();
      int d;
      run_init(16'd5, d);
      chk(d == 2, "R11 two done pulses", d, 2);
      chk(m_ctrl == 16'h0011, "R11 control word", m_ctrl, 16'h0011);
      chk(m_addr == 16'd5, "R11 start address", m_addr, 5);
   endtask

   task automatic t_write_inc();
      logic [15:0] r;
      int w0 = wr_words;
      access(2'b01, 1'b0, 16'h1234, r);
      access(2'b01, 1'b0, 16'hBEEF, r);
      access(2'b01, 1'b0, 16'h0F0F, r);
      chk(m_mem[5] == 16'h1234 && m_mem[6] == 16'hBEEF && m_mem[7] == 16'h0F0F,
          "R3 write byte order", m_mem[6], 16'hBEEF);
      chk(m_addr == 16'd8, "R2 auto-increment select", m_addr, 8);
      chk(wr_words == w0 + 3, "R2 write count", wr_words, w0 + 3);
   endtask

   task automatic t_read_fix();
      logic [15:0] r;
      access(2'b11, 1'b1, 16'h0, r);
      chk(r == 16'hA55A, "R6 fixed read", r, 16'hA55A);
      access(2'b11, 1'b1, 16'h0, r);
      chk(r == 16'hA55A, "R6 fixed read repeat", r, 16'hA55A);
      chk(m_addr == 16'd8, "R2 no-increment select", m_addr, 8);
   endtask

   task automatic t_read_inc();
      logic [15:0] r;
      access(2'b10, 1'b0, 16'd5, r);
      chk(m_addr == 16'd5, "R2 address write", m_addr, 5);
      access(2'b01, 1'b1, 16'h0, r);
      chk(r == 16'h1234, "R3 read byte order", r, 16'h1234);
      access(2'b01, 1'b1, 16'h0, r);
      chk(r == 16'hBEEF, "R6 read inc", r, 16'hBEEF);
      access(2'b01, 1'b1, 16'h0, r);
      chk(r == 16'h0F0F, "R6 read inc", r, 16'h0F0F);
      chk(m_addr == 16'd8, "R2 read increment", m_addr, 8);
   endtask

   task automatic t_ready_wait();
      logic [15:0] r;
      rdy_low = 12; chk_rel = 1; rel_seen = 0;
      access(2'b11, 1'b0, 16'h5A5A, r);
      chk_rel = 0; rdy_low = 3;
      chk(rel_seen == 1, "R8 release observed", rel_seen, 1);
      chk(m_mem[8] == 16'h5A5A, "R8 write landed", m_mem[8], 16'h5A5A);
   endtask

   task automatic t_req_held();
      int w0 = wr_words;
      int n = 0;
      @(negedge clk); force_nr = 1;
      repeat (6) @(negedge clk);
      req_valid = 1'b1; req_sel = 2'b11; req_rd = 1'b0; req_wdata = 16'h6161;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(!busy && hp_strb_n, "R9 held while not ready", {busy, hp_strb_n}, 2'b01);
      end
      force_nr = 0;
      while (!busy && n < 8) begin @(negedge clk); n++; end
      chk(busy && n <= 5, "R9 accepted after ready", n, 5);
      req_valid = 1'b0;
      do @(negedge clk); while (!done);
      @(negedge clk);
      chk(wr_words == w0 + 1 && m_mem[8] == 16'h6161, "R9 one write", wr_words, w0 + 1);
   endtask

   task automatic t_ignore_busy();
      int w0 = wr_words;
      @(negedge clk);
      req_valid = 1'b1; req_sel = 2'b11; req_rd = 1'b0; req_wdata = 16'hCAFE;
      do @(negedge clk); while (!busy);
      req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_wdata = 16'hDEAD; init_start = 1'b1; init_addr = 16'd2;
      @(negedge clk);
      req_valid = 1'b0; init_start = 1'b0;
      do @(negedge clk); while (!done);
      repeat (15) @(negedge clk);
      chk(!busy, "R10 nothing queued", busy, 0);
      chk(wr_words == w0 + 1, "R10 write count", wr_words, w0 + 1);
      chk(m_mem[8] == 16'hCAFE, "R10 first data kept", m_mem[8], 16'hCAFE);
      chk(m_addr == 16'd8, "R10 start ignored", m_addr, 8);
   endtask

   task automatic t_priority();
      int w0 = wr_words;
      int d = 0;
      @(negedge clk);
      init_start = 1'b1; init_addr = 16'd9;
      req_valid = 1'b1; req_sel = 2'b11; req_rd = 1'b0; req_wdata = 16'h7777;
      @(negedge clk);
      init_start = 1'b0; req_valid = 1'b0;
      while (busy) begin
         if (done) d++;
         @(negedge clk);
      end
      chk(d == 2, "R12 set-up ran", d, 2);
      chk(wr_words == w0, "R12 local dropped", wr_words, w0);
      chk(m_addr == 16'd9, "R12 address loaded", m_addr, 9);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = 16'h1000 + 16'(i);
      m_mem[8] = 16'hA55A;
      repeat (3) @(negedge clk);
      t_reset();
      t_init();
      t_write_inc();
      t_read_fix();
      t_read_inc();
      t_ready_wait();
      t_req_held();
      t_ignore_busy();
      t_priority();
      repeat (5) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule